// File: doc/BRIEF.md
# Control-Register Parallel Access Master

This block performs single 16-bit reads and writes on a PHY's control-register parallel port for a host that offers one request at a time. The port has no free-running clock. The master makes a slow strobe itself by dividing the system clock, so every strobe phase lasts a fixed, parameterised number of system cycles. It drives the address, the write data and separate write and read enables, and it watches an acknowledge line coming back from the PHY.

Every access starts by putting the port in a known state. The master zeroes the address and the data, drops both enables, drives the strobe low and raises the parallel-source select. It then pulses the strobe until acknowledge is seen low. Next it runs the address and enable phases, which differ between a write and a read. After that it raises the strobe repeatedly and samples acknowledge at the end of each high phase. If no acknowledge arrives within a bounded number of polls, the access ends with an error. A read returns the upper half of a 32-bit status word captured once the access succeeds. A failed read returns all ones.

The host raises a request for one cycle while the block is idle. The block holds busy until a single-cycle done pulse, and that pulse carries the error flag.

Top module: `crp_master`

## Requirements
- R1: While reset is held and after its release, busy, done, error, strobe, select, both enables and the address output are all low. While idle the strobe and both enables stay low.
- R2: An access begins with a clear phase. The address and data are driven to zero, both enables are low, select goes high and the strobe is low. The strobe is then pulsed one cycle at a time, and the block leaves the phase only after a high-then-low pulse that ends with acknowledge sampled low. That is one pulse when acknowledge is already low, and one more pulse for each extra pulse the PHY keeps it high.
- R3: For a write, the address appears together with a strobe rise. Write-enable and data are then applied while the strobe is low. Write-enable covers exactly one strobe rising edge and is released while the strobe is low. It never changes in the same cycle as the strobe, and it is never high together with read-enable.
- R4: For a read, read-enable rises together with the address and the strobe, and stays high over exactly two strobe rising edges. It falls while the strobe is held high, before the next strobe fall.
- R5: After the enable phase the strobe is raised and acknowledge is sampled at the end of each high phase. On acknowledge the strobe is driven low and the access ends without error. Acknowledge arriving on the tenth poll still counts as success.
- R6: When ten polls pass without acknowledge, the access ends with the error flag set. A read then returns 16'hFFFF. A write leaves the read-data output unchanged. The error flag is only ever high together with done.
- R7: A successful read returns bits 31:16 of the status word, sampled at the end of the access.
- R8: A request is taken only while idle. Busy is high from the accepting edge until the edge that raises done. Done lasts one cycle. A request made while busy has no effect on the port or on any later result.
- R9: Every strobe phase lasts HALF_PERIOD system cycles. An access with n clear pulses and acknowledge on poll d lasts (2n+2d+7)·HALF_PERIOD cycles for a write and (2n+2d+6)·HALF_PERIOD cycles for a read. A timed-out access lasts (2n+27)·HALF_PERIOD cycles for a write and (2n+26)·HALF_PERIOD cycles for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, taken when idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Register address |
| req_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Acknowledge timeout, valid with done |
| rdata_o | output | 16 | Read result |
| port_clk_o | output | 1 | Generated port strobe |
| port_sel_o | output | 1 | Parallel strobe source select |
| port_addr_o | output | 16 | Port address bus |
| port_wdata_o | output | 16 | Port write data |
| port_wr_en_o | output | 1 | Port write enable |
| port_rd_en_o | output | 1 | Port read enable |
| port_ack_i | input | 1 | Port acknowledge |
| port_status_i | input | 32 | Status word, read data in upper half |

## Verification
The assertions assume that acknowledge changes only in response to strobe rising edges and then settles well inside a strobe phase. They also assume the host pulses a request only when it wants a new access. The bench's PHY model moves acknowledge only at strobe rises, using a chosen poll delay and a chosen count of extra pulses it holds acknowledge high. The bench runs the strobe at four system cycles per phase, which leaves acknowledge more than the synchroniser depth ahead of each sampling point. Requests come as one-cycle pulses, and one deliberate stray pulse lands in the middle of a read.

// File: rtl/crp_pkg.sv
package crp_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // One state per strobe half-period; ordering is the access sequence.
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CLR_SET,
      ST_CLR_HI,
      ST_CLR_LO,
      ST_ADR_HI,
      ST_ADR_LO,
      ST_WEN_SET,
      ST_EN_HI,
      ST_RD_DROP,
      ST_EN_LO,
      ST_WR_DROP,
      ST_POLL_HI,
      ST_POLL_LO,
      ST_FIN_LO
   } crp_state_e;

   // Strobe level driven while a given state is active.
   function automatic logic strobe_level(input crp_state_e s);
      case (s)
         ST_CLR_HI, ST_ADR_HI, ST_EN_HI, ST_RD_DROP, ST_POLL_HI: strobe_level = 1'b1;
         default:                                                strobe_level = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/crp_half_timer.sv
module crp_half_timer #(
   parameter int unsigned HALF_PERIOD = 200
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic tick_o
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

   logic [CNT_W-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (!run_i || tick_o) cnt_q <= '0;
      else                       cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/crp_ack_sync.sv
module crp_ack_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ack_i,
   output logic ack_o
);
   timeunit 1ns;
   timeprecision 1ps;

   generate
      if (STAGES == 0) begin : g_bypass
         assign ack_o = ack_i;
      end else begin : g_chain
         logic [STAGES-1:0] sync_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               sync_q <= '0;
            end else begin
               sync_q[0] <= ack_i;
               for (int i = 1; i < int'(STAGES); i++) sync_q[i] <= sync_q[i-1];
            end
         end
         assign ack_o = sync_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/crp_seq.sv
module crp_seq
   import crp_pkg::*;
#(
   parameter int unsigned POLL_LIMIT = 10
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       req_i,
   input  logic       write_i,
   input  logic       tick_i,
   input  logic       ack_i,
   output crp_state_e state_o,
   output crp_state_e state_next_o,
   output logic       accept_o,
   output logic       adv_o,
   output logic       done_ok_o,
   output logic       done_fail_o
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned PW = $clog2(POLL_LIMIT + 1);
   localparam logic [PW-1:0] LAST_POLL = PW'(POLL_LIMIT - 1);

   crp_state_e    state_q, state_d;
   logic [PW-1:0] poll_q, poll_d;

   always_comb begin
      state_d     = state_q;
      poll_d      = poll_q;
      done_ok_o   = 1'b0;
      done_fail_o = 1'b0;
      accept_o    = (state_q == ST_IDLE) && req_i;
      if (accept_o) begin
         state_d = ST_CLR_SET;
         poll_d  = '0;
      end else if (tick_i) begin
         case (state_q)
            ST_CLR_SET: state_d = ST_CLR_HI;
            ST_CLR_HI:  state_d = ST_CLR_LO;
            ST_CLR_LO:  state_d = ack_i ? ST_CLR_HI : ST_ADR_HI;
            ST_ADR_HI:  state_d = ST_ADR_LO;
            ST_ADR_LO:  state_d = write_i ? ST_WEN_SET : ST_EN_HI;
            ST_WEN_SET: state_d = ST_EN_HI;
            ST_EN_HI:   state_d = write_i ? ST_EN_LO : ST_RD_DROP;
            ST_RD_DROP: state_d = ST_EN_LO;
            ST_EN_LO:   state_d = write_i ? ST_WR_DROP : ST_POLL_HI;
            ST_WR_DROP: state_d = ST_POLL_HI;
            ST_POLL_HI: state_d = ack_i ? ST_FIN_LO : ST_POLL_LO;
            ST_POLL_LO: begin
               if (poll_q == LAST_POLL) begin
                  state_d     = ST_IDLE;
                  done_fail_o = 1'b1;
               end else begin
                  poll_d  = poll_q + PW'(1);
                  state_d = ST_POLL_HI;
               end
            end
            ST_FIN_LO: begin
               state_d   = ST_IDLE;
               done_ok_o = 1'b1;
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         poll_q  <= '0;
      end else begin
         state_q <= state_d;
         poll_q  <= poll_d;
      end
   end

   assign state_o      = state_q;
   assign state_next_o = state_d;
   assign adv_o        = accept_o || tick_i;
endmodule

// File: rtl/crp_port_drv.sv
module crp_port_drv
   import crp_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              adv_i,
   input  crp_state_e        state_next_i,
   input  logic              write_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              strobe_o,
   output logic              sel_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              wr_en_o,
   output logic              rd_en_o
);
   timeunit 1ns;
   timeprecision 1ps;

   // Entry actions: every port line is a flop updated when a state is entered.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         strobe_o <= 1'b0;
         sel_o    <= 1'b0;
         addr_o   <= '0;
         wdata_o  <= '0;
         wr_en_o  <= 1'b0;
         rd_en_o  <= 1'b0;
      end else if (adv_i) begin
         strobe_o <= strobe_level(state_next_i);
         case (state_next_i)
            ST_CLR_SET: begin
               addr_o  <= '0;
               wdata_o <= '0;
               wr_en_o <= 1'b0;
               rd_en_o <= 1'b0;
               sel_o   <= 1'b1;
            end
            ST_ADR_HI: begin
               addr_o  <= addr_i;
               rd_en_o <= !write_i;
            end
            ST_WEN_SET: begin
               wdata_o <= wdata_i;
               wr_en_o <= 1'b1;
            end
            ST_RD_DROP: rd_en_o <= 1'b0;
            ST_WR_DROP: wr_en_o <= 1'b0;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/crp_master.sv
module crp_master
   import crp_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned STATUS_W    = 32,
   parameter int unsigned HALF_PERIOD = 200,
   parameter int unsigned POLL_LIMIT  = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                req_i,
   input  logic                req_write_i,
   input  logic [ADDR_W-1:0]   req_addr_i,
   input  logic [DATA_W-1:0]   req_wdata_i,
   output logic                busy_o,
   output logic                done_o,
   output logic                err_o,
   output logic [DATA_W-1:0]   rdata_o,
   output logic                port_clk_o,
   output logic                port_sel_o,
   output logic [ADDR_W-1:0]   port_addr_o,
   output logic [DATA_W-1:0]   port_wdata_o,
   output logic                port_wr_en_o,
   output logic                port_rd_en_o,
   input  logic                port_ack_i,
   input  logic [STATUS_W-1:0] port_status_i
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned RD_LSB = STATUS_W - DATA_W;

   generate
      if (STATUS_W < DATA_W) begin : g_bad_status
         $error("crp_master: STATUS_W must be at least DATA_W");
      end
      if (HALF_PERIOD <= SYNC_STAGES + 1) begin : g_bad_half
         $error("crp_master: HALF_PERIOD must exceed SYNC_STAGES + 1");
      end
      if (POLL_LIMIT < 1) begin : g_bad_poll
         $error("crp_master: POLL_LIMIT must be at least 1");
      end
      if (RD_LSB > 0) begin : g_low_status
         logic unused_status_low;
         assign unused_status_low = ^port_status_i[RD_LSB-1:0];
      end
   endgenerate

   crp_state_e        state_q, state_d;
   logic              accept, adv, tick, ack_s, done_ok, done_fail;
   logic              op_write_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              done_q, err_q;
   logic [DATA_W-1:0] rdata_q;

   assign busy_o = (state_q != ST_IDLE);

   crp_half_timer #(.HALF_PERIOD(HALF_PERIOD)) timer_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (busy_o),
      .tick_o (tick)
   );

   crp_ack_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ack_i  (port_ack_i),
      .ack_o  (ack_s)
   );

   crp_seq #(.POLL_LIMIT(POLL_LIMIT)) seq_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_i        (req_i),
      .write_i      (op_write_q),
      .tick_i       (tick),
      .ack_i        (ack_s),
      .state_o      (state_q),
      .state_next_o (state_d),
      .accept_o     (accept),
      .adv_o        (adv),
      .done_ok_o    (done_ok),
      .done_fail_o  (done_fail)
   );

   crp_port_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) drv_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .adv_i        (adv),
      .state_next_i (state_d),
      .write_i      (op_write_q),
      .addr_i       (addr_q),
      .wdata_i      (wdata_q),
      .strobe_o     (port_clk_o),
      .sel_o        (port_sel_o),
      .addr_o       (port_addr_o),
      .wdata_o      (port_wdata_o),
      .wr_en_o      (port_wr_en_o),
      .rd_en_o      (port_rd_en_o)
   );

   // Request capture: only an accepted request reaches these registers.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         op_write_q <= 1'b0;
         addr_q     <= '0;
         wdata_q    <= '0;
      end else if (accept) begin
         op_write_q <= req_write_i;
         addr_q     <= req_addr_i;
         wdata_q    <= req_wdata_i;
      end
   end

   // Completion and result.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         done_q <= done_ok || done_fail;
         err_q  <= done_fail;
         if (!op_write_q) begin
            if (done_ok)        rdata_q <= port_status_i[STATUS_W-1 -: DATA_W];
            else if (done_fail) rdata_q <= '1;
         end
      end
   end

   assign done_o  = done_q;
   assign err_o   = err_q;
   assign rdata_o = rdata_q;
endmodule

// File: rtl/crp_master_chk.sv
module crp_master_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic req_i,
   input logic busy_o,
   input logic done_o,
   input logic err_o,
   input logic port_clk_o,
   input logic port_wr_en_o,
   input logic port_rd_en_o
);
   timeunit 1ns;
   timeprecision 1ps;

   assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (!port_clk_o && !port_wr_en_o && !port_rd_en_o));

   assert_en_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(port_wr_en_o && port_rd_en_o));

   assert_wr_edge_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(port_wr_en_o) || $fell(port_wr_en_o)) |-> ($stable(port_clk_o) && !port_clk_o));

   assert_rd_rise_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(port_rd_en_o) |-> $rose(port_clk_o));

   assert_rd_fall_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(port_rd_en_o) |-> ($stable(port_clk_o) && port_clk_o));

   assert_err_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> done_o);

   assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   assert_start_on_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> $past(req_i));
endmodule

bind crp_master crp_master_chk chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .req_i        (req_i),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .err_o        (err_o),
   .port_clk_o   (port_clk_o),
   .port_wr_en_o (port_wr_en_o),
   .port_rd_en_o (port_rd_en_o)
);

// File: tb/crp_master_tb_top.sv
module crp_master_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned HP    = 4;
   localparam int          LIMIT = 10;

   typedef struct packed {
      logic        wr;
      logic [15:0] addr;
      logic [15:0] data;
      logic [7:0]  dly;
      logic [3:0]  stk;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 16'h0003, 16'h1234, 8'd1,  4'd0},
      '{1'b1, 16'h0007, 16'hBEEF, 8'd10, 4'd0},
      '{1'b0, 16'h0003, 16'h0000, 8'd1,  4'd0},
      '{1'b0, 16'h0007, 16'h0000, 8'd7,  4'd2},
      '{1'b1, 16'h0005, 16'h0F0F, 8'd11, 4'd0},
      '{1'b0, 16'h0005, 16'h0000, 8'd11, 4'd0},
      '{1'b0, 16'h0005, 16'h0000, 8'd3,  4'd0},
      '{1'b1, 16'h000A, 16'hFFFF, 8'd4,  4'd3},
      '{1'b0, 16'h000A, 16'h0000, 8'd10, 4'd0},
      '{1'b0, 16'h0001, 16'h0000, 8'd2,  4'd0},
      '{1'b1, 16'h0001, 16'h8001, 8'd2,  4'd1},
      '{1'b0, 16'h0001, 16'h0000, 8'd1,  4'd0}
   };

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n, req, req_wr;
   logic [15:0] req_addr, req_wdata;
   logic        busy, done, err;
   logic [15:0] rdata;
   logic        pclk, psel, pwr, prd;
   logic [15:0] paddr, pwdata;
   logic        pack;
   logic [31:0] pstatus;

   crp_master #(.HALF_PERIOD(HP)) dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .req_i         (req),
      .req_write_i   (req_wr),
      .req_addr_i    (req_addr),
      .req_wdata_i   (req_wdata),
      .busy_o        (busy),
      .done_o        (done),
      .err_o         (err),
      .rdata_o       (rdata),
      .port_clk_o    (pclk),
      .port_sel_o    (psel),
      .port_addr_o   (paddr),
      .port_wdata_o  (pwdata),
      .port_wr_en_o  (pwr),
      .port_rd_en_o  (prd),
      .port_ack_i    (pack),
      .port_status_i (pstatus)
   );

   // PHY model: reacts only to strobe rising edges.
   logic [15:0] mem [16];
   logic [15:0] rdval;
   logic        pending;
   int          acnt, ack_delay, stick;
   int          clr_rises, wr_rises, rd_rises;

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 16'h0000;
      rdval = 16'h0000; pending = 1'b0; pack = 1'b0;
      acnt = 0; ack_delay = 1; stick = 0;
      clr_rises = 0; wr_rises = 0; rd_rises = 0;
   end

   always @(posedge pclk) begin
      if (pwr || prd) begin
         if (pwr) begin mem[paddr[3:0]] = pwdata; wr_rises++; end
         if (prd) begin rdval = mem[paddr[3:0]]; rd_rises++; end
         pending = 1'b1;
         acnt    = 0;
      end else if (paddr == 16'h0000) begin
         clr_rises++;
         pending = 1'b0;
         if (pack) begin
            if (stick > 0) stick--;
            else           pack = 1'b0;
         end
      end else if (pending) begin
         acnt++;
         if (acnt == ack_delay) begin pack = 1'b1; pending = 1'b0; end
      end
   end

   assign pstatus = {rdval, 16'hA5A5};

   int total = 0;
   int bad   = 0;
   logic [15:0] shadow [16];
   logic [15:0] last_rd;
   int          done_seen;

   always @(posedge clk) if (done) done_seen++;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_access(input logic wr, input logic [15:0] a, input logic [15:0] d,
                             input int dly, input int stk);
      int n_exp, s_exp, k;
      logic exp_err;
      logic [15:0] exp_rd;
      n_exp   = pack ? stk + 1 : 1;
      exp_err = (dly > LIMIT);
      if (wr) s_exp = exp_err ? 2*n_exp + 27 : 2*n_exp + 2*dly + 7;
      else    s_exp = exp_err ? 2*n_exp + 26 : 2*n_exp + 2*dly + 6;
      if (wr)           exp_rd = last_rd;
      else if (exp_err) exp_rd = 16'hFFFF;
      else              exp_rd = shadow[a[3:0]];
      if (wr) shadow[a[3:0]] = d;
      ack_delay = dly; stick = stk;
      clr_rises = 0; wr_rises = 0; rd_rises = 0;
      @(negedge clk);
      req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
      chk(busy == 1'b1, "R8 busy after accept", 32'(busy), 32'd1);
      k = 0;
      while (!done && k < 5000) begin
         @(posedge clk);
         k++;
         @(negedge clk);
      end
      chk(k == s_exp * int'(HP), "R9 access length", 32'(k), 32'(s_exp * int'(HP)));
      chk(err == exp_err, exp_err ? "R6 timeout flag" : "R5 ack success", 32'(err), 32'(exp_err));
      chk(rdata == exp_rd, wr ? "R6 rdata kept on write" : (exp_err ? "R6 read error ones" : "R7 read data"),
          32'(rdata), 32'(exp_rd));
      chk(busy == 1'b0, "R8 busy low at done", 32'(busy), 32'd0);
      chk(clr_rises == n_exp, "R2 clear pulses", 32'(clr_rises), 32'(n_exp));
      chk(psel == 1'b1, "R2 select high", 32'(psel), 32'd1);
      if (wr) chk(wr_rises == 1 && rd_rises == 0, "R3 write enable rises", 32'(wr_rises), 32'd1);
      else    chk(rd_rises == 2 && wr_rises == 0, "R4 read enable rises", 32'(rd_rises), 32'd2);
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", 32'(done), 32'd0);
      last_rd = exp_rd;
   endtask

   initial begin
      for (int i = 0; i < 16; i++) shadow[i] = 16'h0000;
      last_rd = 16'h0000; done_seen = 0;
      rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      chk({busy, done, err, pclk, psel, pwr, prd} == 7'b0, "R1 outputs in reset",
          32'({busy, done, err, pclk, psel, pwr, prd}), 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({busy, done, err, pclk, psel, pwr, prd} == 7'b0 && paddr == 16'h0, "R1 outputs after reset",
          32'({busy, done, err, pclk, psel, pwr, prd}), 32'd0);

      for (int i = 0; i < NV; i++)
         run_access(VECS[i].wr, VECS[i].addr, VECS[i].data, int'(VECS[i].dly), int'(VECS[i].stk));

      // R8: a request pulsed mid-access must be dropped.
      done_seen = 0;
      fork
         run_access(1'b0, 16'h0003, 16'h0000, 2, 0);
         begin
            repeat (30) @(negedge clk);
            req = 1'b1; req_wr = 1'b1; req_addr = 16'h0009; req_wdata = 16'h5555;
            @(negedge clk);
            req = 1'b0;
         end
      join
      repeat (10) @(negedge clk);
      chk(busy == 1'b0, "R8 no access from stray request", 32'(busy), 32'd0);
      chk(done_seen == 1, "R8 single completion", 32'(done_seen), 32'd1);
      chk(pclk == 1'b0 && pwr == 1'b0 && prd == 1'b0, "R1 idle port quiet",
          32'({pclk, pwr, prd}), 32'd0);
      run_access(1'b0, 16'h0009, 16'h0000, 1, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule